// File: doc/BRIEF.md
# Length-Filtered Cascadable SPI Receiver

This block is a serial slave that receives a 12-bit settings word over SPI and holds it on a parallel output register. A host lowers chip select and clocks in the word most significant bit first. The word is transferred to the output register when chip select returns high. The transfer happens only if the frame carried at least 12 clocks, so a glitch or a truncated transfer cannot overwrite the settings. Frames longer than 12 bits are accepted and keep their final 12 bits. A host that can only move 16-bit words therefore prepends 4 dummy bits.

The serial output carries the bit leaving the top of the shift register. Several devices can be chained into one long shift path this way. The output is driven only while chip select is low and the enable input is active. All SPI pins are oversampled by a fast system clock through two-flop synchronizers, and SCK edges are detected in that clock domain. For correct operation, each SCK phase must last several system clocks.

Top module: `spi_lf_rx`

## Requirements
- R1: After reset, `cfg_word` is 0, `cfg_load` is 0 and `sdo_oe` is 0.
- R2: While chip select is low and enable is active, each SCK rising edge shifts SDI into the shift register LSB side. The first bit on the wire ends up in bit 11, so an exact 12-bit frame commits the word MSB first.
- R3: A frame with fewer than 12 SCK rising edges leaves `cfg_word` unchanged and produces no `cfg_load` pulse.
- R4: A frame with more than 12 SCK rising edges commits the last 12 bits shifted in. The bit counter saturates at 12.
- R5: An accepted frame updates `cfg_word` after chip select rises. `cfg_load` is then high for exactly one system clock, once per accepted frame.
- R6: `sdo` shows bit 11 of the shift register. It is loaded when chip select falls and after every SCK falling edge. The bits shifted out are therefore the register contents left from earlier frames, followed by the new bits, for daisy-chaining.
- R7: `sdo_oe` is 0 whenever chip select is high or `spi_en_n` is high. It is 1 while both are low.
- R8: While `spi_en_n` is high, SCK edges have no effect. The shift register is unchanged, and such a frame is not accepted.
- R9: The bit counter clears when chip select falls. A short frame that follows a long frame is therefore rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_sdi | input | 1 | Serial data in |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_en_n | input | 1 | Active-low enable |
| sdo | output | 1 | Serial data out toward the next device |
| sdo_oe | output | 1 | Output enable for the serial output pad (1 = drive) |
| cfg_word | output | 12 | Committed settings word |
| cfg_load | output | 1 | One-cycle pulse when a new word is committed |

## Verification
Frames of every length from 0 to 16 bits are sent, each with a distinct bit pattern. Lengths below 12 show that the length filter rejects them. Length 12 shows exact MSB-first placement, and longer lengths show that the last 12 bits win. Walking-one and walking-zero words are also sent. They tell apart a swapped or shifted bit order from a correct one, and the serial output is compared bit by bit against a shift model to confirm the chaining order. A disabled frame, and a short frame following a long one, separate a correct enable gate from a broken one and a correctly cleared counter from a stale one.

// File: rtl/spi_lf_pkg.sv
// Shared constants for the length-filtered SPI receiver.
// Assumes: all users take their default widths from here.
package spi_lf_pkg;
    localparam int unsigned DEF_WORD_W      = 12;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Width needed for a counter that saturates at word_w.
    function automatic int unsigned cnt_width(input int unsigned word_w);
        return $clog2(word_w + 1);
    endfunction
endpackage

// File: rtl/spi_lf_sync.sv
// Multi-bit flop-chain synchronizer; each bit is an independent level.
// Assumes: inputs are slow compared to clk, and STAGES >= 1.
module spi_lf_sync #(
    parameter int unsigned     WIDTH   = 4,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d_in;
            for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_out = pipe[STAGES-1];
endmodule

// File: rtl/spi_lf_shifter.sv
// Shift register, saturating bit counter and serial output register.
// Assumes: inputs are already synchronized to clk; chip select active low.
module spi_lf_shifter #(
    parameter int unsigned WORD_W = spi_lf_pkg::DEF_WORD_W,
    localparam int unsigned CNT_W = spi_lf_pkg::cnt_width(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              csn_s,
    input  logic              en_act,
    output logic [WORD_W-1:0] shreg,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              cs_rise,
    output logic              sdo_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

    logic sck_prev;
    logic csn_prev;
    logic sck_rise;
    logic sck_fall;
    logic cs_fall;
    logic live;

    assign live     = ~csn_s & en_act;
    assign sck_rise = sck_s & ~sck_prev;
    assign sck_fall = ~sck_s & sck_prev;
    assign cs_fall  = ~csn_s & csn_prev;
    assign cs_rise  = csn_s & ~csn_prev;

    // Remember previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            csn_prev <= 1'b1;
        end else begin
            sck_prev <= sck_s;
            csn_prev <= csn_s;
        end
    end

    // Shift SDI in at each qualified SCK rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (live && sck_rise) begin
            shreg <= {shreg[WORD_W-2:0], sdi_s};
        end
    end

    // Count qualified rising edges, saturating at the word width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
        end else if (live && sck_rise && bit_cnt != CNT_MAX) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Present the top bit on select and after each SCK falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else if (cs_fall || (live && sck_fall)) begin
            sdo_q <= shreg[WORD_W-1];
        end
    end

    AST_NO_SHIFT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |=> $stable(shreg)); // R8
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_MAX); // R4
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> bit_cnt == '0); // R9
endmodule

// File: rtl/spi_lf_commit.sv
// Commits the shift register to the settings register on chip-select release.
// Assumes: bit_cnt is stable at the cycle cs_rise is seen.
module spi_lf_commit #(
    parameter int unsigned WORD_W = spi_lf_pkg::DEF_WORD_W,
    localparam int unsigned CNT_W = spi_lf_pkg::cnt_width(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [WORD_W-1:0] shreg,
    output logic [WORD_W-1:0] cfg_q,
    output logic              load_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

    // Accept the word only when the frame carried a full word of clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (cs_rise && bit_cnt == CNT_MAX) begin
                cfg_q  <= shreg;
                load_q <= 1'b1;
            end
        end
    end

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_q |-> cfg_q == $past(cfg_q)); // R3
    AST_LOAD_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> $past(bit_cnt) == CNT_MAX); // R3
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |=> !load_q); // R5
endmodule

// File: rtl/spi_lf_rx.sv
// Top of the length-filtered SPI receiver: synchronizers, shifter, commit.
// Assumes: each SCK phase spans several clk cycles; SPI mode 0 timing.
module spi_lf_rx #(
    parameter int unsigned WORD_W      = spi_lf_pkg::DEF_WORD_W,
    parameter int unsigned SYNC_STAGES = spi_lf_pkg::DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_sdi,
    input  logic              spi_cs_n,
    input  logic              spi_en_n,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] cfg_word,
    output logic              cfg_load
);
    localparam int unsigned CNT_W = spi_lf_pkg::cnt_width(WORD_W);

    logic [3:0]        pins_s;
    logic              sck_s, sdi_s, csn_s, en_n_s, en_act;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              cs_rise;

    spi_lf_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1100)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({spi_en_n, spi_cs_n, spi_sdi, spi_sck}),
        .q_out(pins_s)
    );

    assign {en_n_s, csn_s, sdi_s, sck_s} = pins_s;
    assign en_act = ~en_n_s;

    spi_lf_shifter #(.WORD_W(WORD_W)) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (sck_s),
        .sdi_s  (sdi_s),
        .csn_s  (csn_s),
        .en_act (en_act),
        .shreg  (shreg),
        .bit_cnt(bit_cnt),
        .cs_rise(cs_rise),
        .sdo_q  (sdo)
    );

    spi_lf_commit #(.WORD_W(WORD_W)) commit_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_rise(cs_rise),
        .bit_cnt(bit_cnt),
        .shreg  (shreg),
        .cfg_q  (cfg_word),
        .load_q (cfg_load)
    );

    // Drive the serial pad only while selected and enabled.
    assign sdo_oe = ~csn_s & en_act;
endmodule

// File: tb/spi_lf_rx_tb.sv
module spi_lf_rx_tb_top;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, sdi = 1'b0, cs_n = 1'b1, en_n = 1'b0;
    logic        sdo, sdo_oe, cfg_load;
    logic [11:0] cfg_word;

    int n_chk = 0, n_fail = 0, loads = 0, cyc = 0;
    logic dbl_pulse = 1'b0, prev_load = 1'b0, done = 1'b0;
    logic [11:0] model = '0, exp_cfg = '0;

    always #2 clk = ~clk;

    spi_lf_rx dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_sdi(sdi),
        .spi_cs_n(cs_n), .spi_en_n(en_n), .sdo(sdo), .sdo_oe(sdo_oe),
        .cfg_word(cfg_word), .cfg_load(cfg_load)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cfg_load) loads <= loads + 1;
        if (cfg_load && prev_load) dbl_pulse <= 1'b1;
        prev_load <= cfg_load;
        if (cyc > 150000 && !done) begin
            n_fail = n_fail + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send an n-bit frame, data bits n-1 down to 0; checks sdo when enabled.
    task automatic frame(input int n, input logic [31:0] bits);
        int   ld0;
        logic enabled;
        ld0 = loads;
        enabled = !en_n;
        cs_n = 1'b0;
        tick(HALF);
        chk("R7 oe in frame", int'(sdo_oe), int'(enabled));
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            tick(HALF);
            if (enabled) chk("R6 sdo bit", int'(sdo), int'(model[11]));
            sck = 1'b1;
            tick(HALF);
            if (enabled) model = {model[10:0], bits[i]};
            sck = 1'b0;
        end
        tick(HALF);
        cs_n = 1'b1;
        tick(HALF);
        if (enabled && n >= 12) begin
            exp_cfg = model;
            chk("R5 one pulse", loads - ld0, 1);
        end else begin
            chk("R3 no pulse", loads - ld0, 0);
        end
        chk(n >= 12 ? (n == 12 ? "R2 exact word" : "R4 last bits") : "R3 kept",
            int'(cfg_word), int'(exp_cfg));
        chk("R7 oe idle", int'(sdo_oe), 0);
    endtask

    initial begin
        tick(4);
        chk("R1 cfg reset", int'(cfg_word), 0);
        chk("R1 load reset", int'(cfg_load), 0);
        chk("R1 oe reset", int'(sdo_oe), 0);
        rst_n = 1'b1;
        tick(6);
        chk("R1 cfg after release", int'(cfg_word), 0);
        // R2 R3 R4: every frame length with distinct data
        for (int n = 0; n <= 16; n++)
            frame(n, 32'hA5C3_96F1 ^ (n * 32'h0001_3579));
        // R2 walking one and walking zero words
        for (int b = 0; b < 12; b++) frame(12, 32'(1) << b);
        for (int b = 0; b < 12; b++) frame(12, ~(32'(1) << b));
        // R9: long frame then a short one must be rejected
        frame(16, 32'h0000_BEEF);
        frame(7, 32'h0000_0055);
        // R8: disabled frame ignored, register contents kept
        en_n = 1'b1;
        frame(12, 32'h0000_0F0F);
        en_n = 1'b0;
        tick(HALF);
        // R8: next frame's sdo stream proves shift register was untouched
        frame(12, 32'h0000_0ABC);
        chk("R5 single-cycle pulse", int'(dbl_pulse), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule